// File: doc/BRIEF.md
# Fractional-N Modulus Sequencer with Noise-Shaped Division

This block sits in the feedback path of a frequency synthesizer. It divides the oscillator clock by a modulus that changes from one divider cycle to the next, so that the long-run average division ratio is an integer part plus a 16-bit fraction. The result is a synthesized frequency of (N + F/2^16) times the reference once the outer loop has settled. The outer loop is the phase comparison, the filter and the oscillator, and none of it is part of this block.

A cascade of up to three 16-bit accumulators produces the modulus offsets. The carries of the three stages are combined through first- and second-difference terms, which push the quantization error towards high frequencies. The shaping follows (1 − z⁻¹)^L, where L is set by the order input. The modulator advances exactly once per divided cycle, on the oscillator edge where the down-counter reaches its terminal count. The counter reloads on that same edge, so a modulus never changes part-way through a cycle. Integer inputs below 8 are not supported.

Top module: `frac_div_ctrl`

## Requirements
- R1: While reset is held, `fb_clk` is low and `modulus` reads 0.
- R2: The first divided cycle after reset lasts exactly `int_part` oscillator clocks, whatever the fraction and order, because all accumulators and carry history start at zero.
- R3: Each divided cycle begins with a rising edge of `fb_clk`. The cycle lasts exactly the value shown on `modulus` during it, m clocks. `fb_clk` is high for the first m − floor(m/2) clocks and low for the rest.
- R4: `int_part`, `frac_word` and `order_sel` are sampled only on the cycle boundary. Changing them mid-cycle leaves the length and the shown modulus of the current cycle unchanged, and the next cycle uses the new values.
- R5: With `order_sel` = 0 the modulus is always `int_part`, and the fraction has no effect.
- R6: With `order_sel` = 1 the modulus of cycle k+1 is N + c1, where c1 is the carry out of bit 16 when `frac_word` is added to accumulator 1 at update k. The modulus is therefore N or N+1. When F is a multiple of 2^12, the 16 cycles that follow the first cycle sum to 16·N + F/2^12.
- R7: With `order_sel` = 2 the offset is c1 + c2 − c2′. Here c2 is the carry of accumulator 2 after it adds the new value of accumulator 1, and the primed term is the same carry from the previous update. The modulus lies within N−1 .. N+2.
- R8: With `order_sel` = 3 the offset adds c3 − 2·c3′ + c3″. Here c3 is the carry of accumulator 3 after it adds the new value of accumulator 2, and the primes mark the previous one and two updates. The modulus lies within N−3 .. N+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator-side clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_part | input | 8 | Integer division ratio N (at least 8) |
| frac_word | input | 16 | Fraction F, ratio = N + F/2^16 |
| order_sel | input | 2 | Shaping order: 0 none, 1, 2 or 3 |
| fb_clk | output | 1 | Divided feedback clock |
| modulus | output | 9 | Modulus of the cycle in progress |

## Verification
The hardest case to reach from the ports is a change of the control inputs in the middle of a divided cycle. The counter reloads only at terminal count, so such a change must not shorten or stretch the cycle already running. The bench waits for a rising edge of `fb_clk`, moves two clocks into the cycle, changes `int_part`, and then times both that cycle and the next. The extreme third-order offsets (N−3 and N+4) need carry patterns that only some fractions produce. The bench therefore runs a tiny fraction at N = 8 and an all-ones fraction at N = 255. A reference model compares every cycle of these runs against its own prediction.

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic               clk_osc,
  input  logic               rst_n,
  input  logic [INT_W-1:0]   int_part,
  input  logic [FRAC_W-1:0]  frac_word,
  input  logic [1:0]         order_sel,
  output logic               fb_clk,
  output logic [INT_W:0]     modulus
);
  localparam int MOD_W = INT_W + 1;
  localparam logic [MOD_W-1:0] ONE = MOD_W'(1);

  logic [MOD_W-1:0]  cnt_q, mod_q, next_mod;
  logic              fb_q;
  logic [FRAC_W-1:0] acc1, acc2, acc3;
  logic              c1, c2, c3, c2d, c3d, c3dd;
  logic [FRAC_W:0]   sum1, sum2, sum3;
  logic signed [3:0] d1, d2, d3, dy;
  logic              tc;

  assign tc   = (cnt_q == '0);
  assign sum1 = {1'b0, acc1} + {1'b0, frac_word};
  assign sum2 = {1'b0, acc2} + {1'b0, sum1[FRAC_W-1:0]};
  assign sum3 = {1'b0, acc3} + {1'b0, sum2[FRAC_W-1:0]};

  assign d1 = $signed({3'b000, c1});
  assign d2 = $signed({3'b000, c2}) - $signed({3'b000, c2d});
  assign d3 = $signed({3'b000, c3}) - $signed({2'b00, c3d, 1'b0}) + $signed({3'b000, c3dd});

  always_comb begin
    case (order_sel)
      2'd1:    dy = d1;
      2'd2:    dy = d1 + d2;
      2'd3:    dy = d1 + d2 + d3;
      default: dy = 4'sd0;
    endcase
  end

  assign next_mod = {1'b0, int_part} + {{(MOD_W-4){dy[3]}}, dy};

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mod_q <= '0;
      fb_q  <= 1'b0;
      acc1  <= '0;
      acc2  <= '0;
      acc3  <= '0;
      c1    <= 1'b0;
      c2    <= 1'b0;
      c3    <= 1'b0;
      c2d   <= 1'b0;
      c3d   <= 1'b0;
      c3dd  <= 1'b0;
    end else if (tc) begin
      cnt_q <= next_mod - ONE;
      mod_q <= next_mod;
      fb_q  <= 1'b1;
      acc1  <= sum1[FRAC_W-1:0];
      acc2  <= sum2[FRAC_W-1:0];
      acc3  <= sum3[FRAC_W-1:0];
      c1    <= sum1[FRAC_W];
      c2    <= sum2[FRAC_W];
      c3    <= sum3[FRAC_W];
      c2d   <= c2;
      c3d   <= c3;
      c3dd  <= c3d;
    end else begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == (mod_q >> 1)) fb_q <= 1'b0;
    end
  end

  assign fb_clk  = fb_q;
  assign modulus = mod_q;
endmodule

module frac_div_ctrl_chk #(
  parameter int INT_W = 8
) (
  input logic             clk_osc,
  input logic             rst_n,
  input logic [INT_W-1:0] int_part,
  input logic [1:0]       order_sel,
  input logic             fb_clk,
  input logic [INT_W:0]   modulus
);
  localparam int MOD_W = INT_W + 1;

  logic             seen;
  logic [MOD_W:0]   len;
  logic [MOD_W-1:0] pmod;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      len  <= '0;
      pmod <= '0;
    end else if (fb_clk && !seen) begin
      seen <= 1'b1;
      len  <= (MOD_W+1)'(1);
      pmod <= modulus;
    end else if ($rose(fb_clk)) begin
      len  <= (MOD_W+1)'(1);
      pmod <= modulus;
    end else begin
      len  <= len + (MOD_W+1)'(1);
    end
  end

  assert_first_is_int_R2: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $rose(rst_n) |=> modulus == {1'b0, $past(int_part)});

  assert_mod_hold_R4: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !$rose(fb_clk) |-> $stable(modulus));

  assert_period_R3: assert property (@(posedge clk_osc) disable iff (!rst_n)
    ($rose(fb_clk) && seen) |-> len == {1'b0, pmod});

  assert_order0_R5: assert property (@(posedge clk_osc) disable iff (!rst_n)
    ($rose(fb_clk) && $past(order_sel) == 2'd0) |-> modulus == {1'b0, $past(int_part)});

  assert_order1_window_R6: assert property (@(posedge clk_osc) disable iff (!rst_n)
    ($rose(fb_clk) && $past(order_sel) == 2'd1) |->
      (modulus == {1'b0, $past(int_part)} || modulus == {1'b0, $past(int_part)} + MOD_W'(1)));

  assert_order2_window_R7: assert property (@(posedge clk_osc) disable iff (!rst_n)
    ($rose(fb_clk) && $past(order_sel) == 2'd2) |->
      (({1'b0, modulus} + (MOD_W+1)'(1)) >= {2'b00, $past(int_part)} &&
       {1'b0, modulus} <= {2'b00, $past(int_part)} + (MOD_W+1)'(2)));

  assert_order3_window_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
    ($rose(fb_clk) && $past(order_sel) == 2'd3) |->
      (({1'b0, modulus} + (MOD_W+1)'(3)) >= {2'b00, $past(int_part)} &&
       {1'b0, modulus} <= {2'b00, $past(int_part)} + (MOD_W+1)'(4)));
endmodule

bind frac_div_ctrl frac_div_ctrl_chk #(.INT_W(INT_W)) u_chk (
  .clk_osc  (clk_osc),
  .rst_n    (rst_n),
  .int_part (int_part),
  .order_sel(order_sel),
  .fb_clk   (fb_clk),
  .modulus  (modulus)
);

// File: tb/test_frac_div_ctrl.sv
module test_frac_div_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [7:0]  n_in;
  logic [15:0] f_in;
  logic [1:0]  ord;
  wire         fb;
  wire  [8:0]  mod;

  frac_div_ctrl i_frac_div_ctrl (
    .clk_osc(clk), .rst_n(rst_n), .int_part(n_in), .frac_word(f_in),
    .order_sel(ord), .fb_clk(fb), .modulus(mod)
  );

  int checks = 0, fails = 0, cyc = 0;
  int q[$];
  string tag;
  bit mon_en = 0, fb_prev = 0, have_prev = 0;
  int idx, prev_exp, clk_len, hi_len, hi_exp, sum_len, sum_acc, sum_exp;

  task automatic check(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // reference: cascade of three 16-bit accumulators, output from previous update's carries
  task automatic build(int n, int f, int o, int k);
    int a1 = 0, a2 = 0, a3 = 0, c1 = 0, c2 = 0, c3 = 0, c2d = 0, c3d = 0, c3dd = 0;
    for (int i = 0; i < k; i++) begin
      int y = 0, s;
      if (o >= 1) y += c1;
      if (o >= 2) y += c2 - c2d;
      if (o >= 3) y += c3 - 2 * c3d + c3dd;
      q.push_back(n + y);
      c2d = c2; c3dd = c3d; c3d = c3;
      s = a1 + f; c1 = s >> 16; a1 = s & 65535;
      s = a2 + a1; c2 = s >> 16; a2 = s & 65535;
      s = a3 + a2; c3 = s >> 16; a3 = s & 65535;
    end
  endtask

  // monitor: pops expected moduli at each cycle start
  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    if (mon_en) begin
      if (fb && !fb_prev) begin
        int e;
        if (have_prev) check(clk_len == prev_exp, "R3 period", clk_len, prev_exp);
        e = q.pop_front();
        check(mod == 9'(e), (idx == 0) ? "R2 first cycle is N" : tag, int'(mod), e);
        if (idx >= 1 && idx <= sum_len) begin
          sum_acc += int'(mod);
          if (idx == sum_len) check(sum_acc == sum_exp, "R6 average over period", sum_acc, sum_exp);
        end
        prev_exp = e; have_prev = 1; clk_len = 1; hi_len = 1; hi_exp = e - e / 2; idx++;
        if (q.size() == 0) mon_en = 0;
      end else begin
        clk_len++;
        if (fb) hi_len++;
        if (!fb && fb_prev && have_prev) check(hi_len == hi_exp, "R3 high time", hi_len, hi_exp);
      end
    end
    fb_prev = fb;
  end

  task automatic run(int n, int f, int o, int k, string t, int sl, int se);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_in = 8'(n); f_in = 16'(f); ord = 2'(o);
    q.delete();
    build(n, f, o, k);
    tag = t; idx = 0; have_prev = 0; sum_len = sl; sum_acc = 0; sum_exp = se;
    mon_en = 1;
    @(negedge clk) rst_n = 1'b1;
    wait (mon_en == 0);
    @(negedge clk);
  endtask

  initial begin
    int l;
    bit p;
    rst_n = 1'b0; n_in = 8'd10; f_in = 16'h1234; ord = 2'd3;
    repeat (3) @(negedge clk);
    check(fb == 1'b0, "R1 fb low in reset", int'(fb), 0);
    check(mod == 9'd0, "R1 modulus zero in reset", int'(mod), 0);

    run(10, 16'h3000, 1, 40, "R6 order1", 16, 163);
    run(12, 16'h8000, 0, 30, "R5 order0", 0, 0);
    run(20, 16'h5A5B, 2, 200, "R7 order2", 0, 0);
    run(8, 16'h0137, 3, 300, "R8 order3 small", 0, 0);
    run(255, 16'hFFFF, 3, 100, "R8 order3 max", 0, 0);
    run(9, 16'hC001, 1, 60, "R6 order1 large", 0, 0);

    // R4: change of inputs in the middle of a cycle
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_in = 8'd10; f_in = 16'h0; ord = 2'd0;
    @(negedge clk) rst_n = 1'b1;
    do @(negedge clk); while (!fb);
    do @(negedge clk); while (fb);
    do @(negedge clk); while (!fb);
    l = 1; p = 1'b1;
    repeat (2) begin @(negedge clk); l++; p = fb; end
    n_in = 8'd20; ord = 2'd3; f_in = 16'hFFFF;
    @(negedge clk); l++; p = fb;
    check(mod == 9'd10, "R4 modulus held mid-cycle", int'(mod), 10);
    forever begin
      @(negedge clk);
      if (fb && !p) break;
      l++; p = fb;
    end
    check(l == 10, "R4 current cycle length kept", l, 10);
    check(mod == 9'd20, "R4 new N used at boundary", int'(mod), 20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule